// File: doc/BRIEF.md
# Load-Multiple Abort Write Guard

This block sits beside the sequencer of a block-transfer load/store-multiple operation. It decides which register-file writes go ahead when the memory system reports a data abort partway through the transfer. When a transfer begins, it captures the register list, the base register number, the write-back request and the transfer direction. It then walks the list from the lowest register number upward, one transfer per clock. It presents the register number of each transfer, together with a write enable for the loaded data.

After an abort the walk does not stop. Every remaining transfer still takes its cycle, but no further loaded value reaches the register file. Because the highest register is always transferred last, an aborted load never changes the program counter. In the cycle after the final transfer, the block issues the base write-back strobe. A load whose list holds the base register normally lets the loaded value win over write-back. After an abort, the written-back address restores the base instead. In that same cycle the block raises a one-cycle exception request if any transfer aborted. The first abort of an operation records the faulting address and a status code in two fault registers.

Top module: `ldm_abort_guard`

## Requirements
- R1: After reset, `busy`, `xfer_valid`, `rf_we`, `wb_we` and `abort_req` are 0, and `fault_addr` and `fault_status` are 0.
- R2: A `start` accepted while idle with a non-empty list causes one transfer cycle per set bit of the list, in the following cycles. Each of these cycles shows `xfer_valid`=1, and `xfer_idx` takes the register numbers in strictly ascending order with no gaps between cycles.
- R3: A `start` with an all-zero list is a no-op: no transfer cycle, no write-back strobe, no exception request, and `busy` stays 0.
- R4: In a load (`is_load`=1) with no abort so far, `rf_we` is 1 in every transfer cycle. In a store, `rf_we` is never 1.
- R5: From the transfer cycle in which `mem_abort` is first 1, `rf_we` is 0 in that cycle and in every later transfer cycle of the operation. The remaining transfers still take place.
- R6: In an aborted load, the transfer of register NREG-1 (the last in order) never has `rf_we`=1.
- R7: In the cycle after the last transfer, `wb_we` is 1 with `wb_idx` equal to the captured base number when write-back was requested and one of these holds: the operation is a store, the base is absent from the list, or an abort occurred.
- R8: In a load with write-back whose list holds the base and that has no abort, `wb_we` stays 0, and the base's transfer has `rf_we`=1.
- R9: On the first abort of an operation, the fault registers load from that cycle. `fault_addr` takes `mem_addr`. `fault_status` bit 5 is 1 for a load and 0 for a store, bit 4 is 1 when the base is in the list, and bits 3:0 hold the register number of the faulting transfer.
- R10: Later aborts in the same operation leave `fault_addr` and `fault_status` unchanged. An operation without an abort also leaves them unchanged.
- R11: `abort_req` pulses for one cycle, in the same cycle as the write-back slot, exactly when any transfer of the operation aborted.
- R12: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| reg_list | input | NREG | One bit per register to transfer |
| base_idx | input | IW | Base register number |
| wb_en | input | 1 | Base write-back requested |
| is_load | input | 1 | 1 = load from memory, 0 = store |
| mem_abort | input | 1 | Abort of the current transfer's memory access |
| mem_addr | input | AW | Address of the current transfer |
| busy | output | 1 | Operation in progress |
| xfer_valid | output | 1 | A transfer occupies this cycle |
| xfer_idx | output | IW | Register number of the current transfer |
| rf_we | output | 1 | Write enable for the loaded data |
| wb_we | output | 1 | Base write-back strobe |
| wb_idx | output | IW | Register that write-back targets |
| abort_req | output | 1 | Data-abort exception request |
| fault_addr | output | AW | Address of the first aborted access |
| fault_status | output | IW+2 | Status of the first aborted access |

## Verification
If the remaining-list register holds a wrong value, it shows up at once as a skipped or repeated `xfer_idx`, or as a transfer count that differs from the list's population. A sticky abort flag that fails to set shows up in the very next transfer cycle as a stray `rf_we`. The same fault surfaces one cycle after the last transfer as a missing `abort_req` or a wrong write-back decision. Corrupt fault capture shows up in the cycle after the abort, and the bench checks it once the operation returns to idle.

// File: rtl/ldm_guard_pkg.sv
package ldm_guard_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_WBCK = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ldm_list_scan.sv
module ldm_list_scan #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec,
    output logic [IW-1:0]   low_idx,
    output logic            only_one
);
    always_comb begin
        low_idx = '0;
        for (int k = NREG - 1; k >= 0; k--) begin
            if (vec[k]) low_idx = IW'(k);
        end
    end

    assign only_one = (vec != '0) && ((vec & (vec - NREG'(1))) == '0);
endmodule

// File: rtl/ldm_fault_cap.sv
module ldm_fault_cap #(
    parameter int AW = 32,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [AW-1:0] addr_in,
    input  logic [SW-1:0] stat_in,
    output logic [AW-1:0] addr_q,
    output logic [SW-1:0] stat_q
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] stat;
    } fault_t;

    fault_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (cap) begin
            f_d.addr = addr_in;
            f_d.stat = stat_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign addr_q = f_q.addr;
    assign stat_q = f_q.stat;

    // R9
    fault_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (addr_q == $past(addr_in)) && (stat_q == $past(stat_in)));
endmodule

// File: rtl/ldm_abort_guard.sv
module ldm_abort_guard #(
    parameter int NREG = 16,
    parameter int AW = 32,
    localparam int IW = $clog2(NREG),
    localparam int SW = IW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] reg_list,
    input  logic [IW-1:0]   base_idx,
    input  logic            wb_en,
    input  logic            is_load,
    input  logic            mem_abort,
    input  logic [AW-1:0]   mem_addr,
    output logic            busy,
    output logic            xfer_valid,
    output logic [IW-1:0]   xfer_idx,
    output logic            rf_we,
    output logic            wb_we,
    output logic [IW-1:0]   wb_idx,
    output logic            abort_req,
    output logic [AW-1:0]   fault_addr,
    output logic [SW-1:0]   fault_status
);
    import ldm_guard_pkg::*;

    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] rem;
        logic [IW-1:0]   base;
        logic            wb;
        logic            load;
        logic            base_in;
        logic            aborted;
    } seq_t;

    seq_t s_d, s_q;

    logic [IW-1:0]   scan_idx;
    logic            scan_last;
    logic [NREG-1:0] cur_bit;
    logic            first_abort;
    logic [SW-1:0]   stat_code;

    ldm_list_scan #(.NREG(NREG)) u_scan (
        .vec      (s_q.rem),
        .low_idx  (scan_idx),
        .only_one (scan_last)
    );

    assign cur_bit = {{(NREG-1){1'b0}}, 1'b1} << scan_idx;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start && (reg_list != '0)) begin
                    s_d.st      = SEQ_XFER;
                    s_d.rem     = reg_list;
                    s_d.base    = base_idx;
                    s_d.wb      = wb_en;
                    s_d.load    = is_load;
                    s_d.base_in = reg_list[base_idx];
                    s_d.aborted = 1'b0;
                end
            end
            SEQ_XFER: begin
                s_d.rem     = s_q.rem & ~cur_bit;
                s_d.aborted = s_q.aborted | mem_abort;
                if (scan_last) s_d.st = SEQ_WBCK;
            end
            SEQ_WBCK: s_d.st = SEQ_IDLE;
            default:  s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st != SEQ_IDLE);
    assign xfer_valid = (s_q.st == SEQ_XFER);
    assign xfer_idx   = scan_idx;
    assign rf_we      = xfer_valid && s_q.load && !s_q.aborted && !mem_abort;
    assign wb_we      = (s_q.st == SEQ_WBCK) && s_q.wb &&
                        (!s_q.load || !s_q.base_in || s_q.aborted);
    assign wb_idx     = s_q.base;
    assign abort_req  = (s_q.st == SEQ_WBCK) && s_q.aborted;

    assign first_abort = xfer_valid && mem_abort && !s_q.aborted;
    assign stat_code   = {s_q.load, s_q.base_in, scan_idx};

    ldm_fault_cap #(.AW(AW), .SW(SW)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (first_abort),
        .addr_in (mem_addr),
        .stat_in (stat_code),
        .addr_q  (fault_addr),
        .stat_q  (fault_status)
    );

    // R2
    ascend_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_idx > $past(xfer_idx)));

    // R5
    post_abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer_valid && mem_abort) && xfer_valid) |-> !rf_we);

    // R6
    top_reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && xfer_idx == IW'(NREG - 1)) |-> !s_q.aborted);

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && s_q.aborted) |=> ($stable(fault_addr) && $stable(fault_status)));

    // R11
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!busy && !abort_req));

    // R7
    wb_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (busy && !xfer_valid && !rf_we));
endmodule

// File: tb/test_ldm_abort_guard.sv
module test_ldm_abort_guard;
    localparam int NREG = 16;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_list = '0;
    logic [3:0]  base_idx = '0;
    logic        wb_en = 1'b0;
    logic        is_load = 1'b0;
    logic        mem_abort = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        busy, xfer_valid, rf_we, wb_we, abort_req;
    logic [3:0]  xfer_idx, wb_idx;
    logic [31:0] fault_addr;
    logic [5:0]  fault_status;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_faddr = '0;
    logic [5:0]  m_fstat = '0;

    always #2 clk = ~clk;

    ldm_abort_guard #(.NREG(NREG), .AW(AW)) i_ldm_abort_guard (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
        .base_idx(base_idx), .wb_en(wb_en), .is_load(is_load),
        .mem_abort(mem_abort), .mem_addr(mem_addr), .busy(busy),
        .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .rf_we(rf_we),
        .wb_we(wb_we), .wb_idx(wb_idx), .abort_req(abort_req),
        .fault_addr(fault_addr), .fault_status(fault_status)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_wb(input logic w, input logic ld, input logic bin, input logic ab);
        return w && (!ld || !bin || ab);
    endfunction

    task automatic run_op(input logic [15:0] lst, input logic [3:0] b, input logic w,
                          input logic ld, input logic [15:0] amask,
                          input logic [31:0] addr0, input bit poke);
        logic ab = 1'b0;
        int   ord = 0;
        int   nab = 0;
        logic bin = lst[b];
        @(negedge clk);
        reg_list = lst; base_idx = b; wb_en = w; is_load = ld; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (lst == '0) begin
            #1;
            check("R3 busy", busy, 0);
            check("R3 xfer_valid", xfer_valid, 0);
            @(negedge clk); #1;
            check("R3 wb_we", wb_we, 0);
            check("R3 abort_req", abort_req, 0);
            return;
        end
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                logic ew;
                mem_abort = amask[i];
                mem_addr  = addr0 + 32'(ord * 4);
                if (poke && ord == 0) begin
                    start = 1'b1; reg_list = ~lst;
                end
                #1;
                check("R2 xfer_valid", xfer_valid, 1);
                check("R2 xfer_idx", xfer_idx, i);
                ew = ld && !ab && !amask[i];
                if (i == 15 && ld && (ab || amask[i])) check("R6 rf_we top", rf_we, 0);
                else if (ab || amask[i])               check("R5 rf_we", rf_we, ew);
                else if (ld && w && i == int'(b))      check("R8 rf_we base", rf_we, ew);
                else                                   check("R4 rf_we", rf_we, ew);
                if (amask[i] && !ab) begin
                    m_faddr = mem_addr;
                    m_fstat = {ld, bin, 4'(i)};
                end
                if (amask[i]) nab++;
                ab  = ab | amask[i];
                ord++;
                @(negedge clk);
                start = 1'b0; mem_abort = 1'b0;
            end
        end
        #1;
        check("R2 done", xfer_valid, 0);
        if (ld && w && bin && !ab) check("R8 wb_we", wb_we, 0);
        else                       check("R7 wb_we", wb_we, exp_wb(w, ld, bin, ab));
        check("R7 wb_idx", wb_idx, b);
        check("R11 abort_req", abort_req, ab);
        @(negedge clk); #1;
        check(poke ? "R12 busy" : "R2 busy", busy, 0);
        if (nab > 1 || nab == 0) begin
            check("R10 fault_addr", fault_addr, m_faddr);
            check("R10 fault_status", fault_status, m_fstat);
        end else begin
            check("R9 fault_addr", fault_addr, m_faddr);
            check("R9 fault_status", fault_status, m_fstat);
        end
    endtask

    bit finished = 0;

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #5;
        check("R1 busy", busy, 0);
        check("R1 rf_we", rf_we, 0);
        check("R1 wb_we", wb_we, 0);
        check("R1 abort_req", abort_req, 0);
        check("R1 fault_addr", fault_addr, 0);
        check("R1 fault_status", fault_status, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 xfer_valid", xfer_valid, 0);

        run_op(16'hFFFF, 4'd5, 1'b1, 1'b1, 16'h0000, 32'h1000, 0);
        run_op(16'hFFFF, 4'd5, 1'b1, 1'b1, 16'h0208, 32'h2000, 0);
        run_op(16'h8421, 4'd2, 1'b1, 1'b0, 16'h0020, 32'h3000, 0);
        run_op(16'h0000, 4'd1, 1'b1, 1'b1, 16'h0000, 32'h4000, 0);
        run_op(16'h8000, 4'd15, 1'b1, 1'b1, 16'h8000, 32'h5000, 0);
        run_op(16'h0F0F, 4'd0, 1'b0, 1'b1, 16'h0001, 32'h6000, 1);
        run_op(16'h00F0, 4'd9, 1'b1, 1'b1, 16'h0000, 32'h7000, 0);

        for (int n = 0; n < 40; n++) begin
            logic [15:0] l = 16'($urandom);
            logic [15:0] m = 16'($urandom) & 16'($urandom) & 16'($urandom);
            if (n % 5 == 0) m = '0;
            run_op(l, 4'($urandom), 1'($urandom), 1'($urandom), m,
                   {$urandom} & 32'hFFFF_FFFC, n % 7 == 3);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule